// File: doc/BRIEF.md
# Ethernet Destination Address Screen

This block decides, for each incoming frame, whether the frame is kept or dropped. The decision uses only the 48-bit destination address. The address is first sorted into one of three classes:

- **broadcast:** all ones.
- **multicast:** bit 0 of the first octet set, and not broadcast.
- **unicast:** anything else.

Each class has its own accept-all switch. Independently of the class switches, the address can be compared with a table of sixteen programmable entries. An enable mask chooses which entries take part in the comparison. The result of the table comparison can be inverted, so the table works as a reject list rather than an accept list.

The frame parser presents the address with a one-cycle strobe. A cycle later the block raises `done` for one cycle, with the registered decision on `accept`. `accept` keeps that value until the next decision.

A small two-state controller sequences the reply:
- **ST_IDLE:** no result is pending. A strobe moves it to ST_REPORT (transition *take*).
- **ST_REPORT:** `done` is high. A further strobe keeps it in ST_REPORT (transition *chain*). No strobe returns it to ST_IDLE (transition *retire*).

Table entries are loaded through a word-wide write port:
- **High word:** holds the first four octets of the address. The first octet sits in bits 31:24.
- **Low word:** holds the last two octets in bits 15:0. Bits 31:16 of a low-word write are discarded.

Top module: `rx_screen`

## Requirements
- R1: When reset is released, `done` and `accept` are 0 and every table entry holds the zero address. With all control bits 0, every frame is rejected.
- R2: Every cycle in which `dst_valid` is 1 is followed by exactly one cycle with `done` at 1. `done` is never 1 in a cycle that does not follow a strobe. Back-to-back strobes keep `done` at 1 and give one fresh decision per strobe.
- R3: When `ctrl[2]` is 1, an all-ones address is accepted.
- R4: When `ctrl[1]` is 1, an address with `dst_addr[40]` set that is not all ones is accepted. An all-ones address is not treated as multicast.
- R5: When `ctrl[0]` is 1, an address with `dst_addr[40]` clear is accepted.
- R6: When `ctrl[4]` is 1 and `ctrl[3]` is 0, an address equal in all 48 bits to an enabled table entry is accepted.
- R7: A table entry whose bit in `entry_en` is 0 never produces a table match.
- R8: When `ctrl[4]` and `ctrl[3]` are both 1, the table result is inverted. An address matching no enabled entry is then accepted, and an address matching one is rejected unless its class bit accepts it.
- R9: When `ctrl[4]` is 0, the table and `ctrl[3]` have no effect. The decision is then the class bit alone.
- R10: A write with `wr_hi` at 1 loads `wr_data` into address bits 47:16 of entry `wr_idx`. A write with `wr_hi` at 0 loads `wr_data[15:0]` into address bits 15:0. A lookup in the cycle after the write sees the new value.
- R11: `accept` changes only at the start of a cycle in which `done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl | input | 5 | Filter controls: [4] table compare on, [3] invert table result, [2] accept broadcast, [1] accept multicast, [0] accept unicast |
| entry_en | input | 16 | One enable bit per table entry |
| wr_en | input | 1 | Table write strobe |
| wr_hi | input | 1 | 1 selects the high word of the entry, 0 the low word |
| wr_idx | input | 4 | Table entry written |
| wr_data | input | 32 | Write data |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, first octet in bits 47:40 |
| done | output | 1 | Decision valid, one cycle after each strobe |
| accept | output | 1 | 1 keeps the frame, 0 drops it |

## Verification
The assertions assume that `ctrl`, `entry_en` and the table are steady in the cycle a strobe is sampled. They also assume that no table write lands in the same cycle as the strobe whose decision depends on that entry.

The stimulus respects these assumptions:
- Control values and enables are changed only between lookups.
- Writes are issued as separate single-cycle operations before the following strobe.

Random addresses are biased toward copies of table contents, the all-ones address and multicast patterns, so that matches and every class occur often.

// File: rtl/rx_screen_pkg.sv
package rx_screen_pkg;

    localparam int CTL_W      = 5;
    localparam int CTL_UCAST  = 0;
    localparam int CTL_MCAST  = 1;
    localparam int CTL_BCAST  = 2;
    localparam int CTL_INVERT = 3;
    localparam int CTL_CMP_ON = 4;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } scr_state_e;

    typedef enum logic [1:0] {
        CLS_UNI   = 2'd0,
        CLS_MULTI = 2'd1,
        CLS_BCAST = 2'd2
    } addr_class_e;

endpackage

// File: rtl/rx_screen_class.sv
module rx_screen_class
    import rx_screen_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_class_e       cls
);
    localparam int GROUP_BIT = ADDR_W - 8;

    always_comb begin
        if (&addr)
            cls = CLS_BCAST;
        else if (addr[GROUP_BIT])
            cls = CLS_MULTI;
        else
            cls = CLS_UNI;
    end
endmodule

// File: rtl/rx_screen_table.sv
module rx_screen_table #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 48,
    parameter int WORD_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int LO_W   = ADDR_W - WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ENTRIES-1:0] entry_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              any_hit
);
    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic [WORD_W-1:0] hi_q;
        logic [LO_W-1:0]   lo_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_q <= '0;
                lo_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                if (wr_hi)
                    hi_q <= wr_data;
                else
                    lo_q <= wr_data[LO_W-1:0];
            end
        end

        assign hit_vec[g] = entry_en[g] && ({hi_q, lo_q} == addr);
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/rx_screen.sv
module rx_screen
    import rx_screen_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 48,
    parameter int WORD_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CTL_W-1:0]   ctrl,
    input  logic [ENTRIES-1:0] entry_en,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               dst_valid,
    input  logic [ADDR_W-1:0]  dst_addr,
    output logic               done,
    output logic               accept
);
    scr_state_e  state_q, state_d;
    addr_class_e cls;
    logic        tbl_hit;
    logic        class_ok;
    logic        table_ok;
    logic        verdict;

    rx_screen_class #(.ADDR_W(ADDR_W)) u_class (
        .addr (dst_addr),
        .cls  (cls)
    );

    rx_screen_table #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .WORD_W  (WORD_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_hi    (wr_hi),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .entry_en (entry_en),
        .addr     (dst_addr),
        .any_hit  (tbl_hit)
    );

    always_comb begin
        unique case (cls)
            CLS_BCAST: class_ok = ctrl[CTL_BCAST];
            CLS_MULTI: class_ok = ctrl[CTL_MCAST];
            default:   class_ok = ctrl[CTL_UCAST];
        endcase
        table_ok = ctrl[CTL_CMP_ON] && (tbl_hit ^ ctrl[CTL_INVERT]);
        verdict  = class_ok || table_ok;
    end

    // next state: take / chain / retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (dst_valid) state_d = ST_REPORT;
            ST_REPORT: state_d = dst_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            accept <= 1'b0;
        else if (dst_valid)
            accept <= verdict;
    end

    assign done = (state_q == ST_REPORT);
endmodule

// File: rtl/rx_screen_chk.sv
module rx_screen_chk
    import rx_screen_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTL_W-1:0]  ctrl,
    input logic              dst_valid,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              tbl_hit,
    input logic              done,
    input logic              accept
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !accept));

    // R2
    reply_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |=> done);

    // R2
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(dst_valid));

    // R11
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(accept));

    // R3
    bcast_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && (&dst_addr) && ctrl[CTL_BCAST]) |=> accept);

    // R6
    table_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && ctrl[CTL_CMP_ON] && !ctrl[CTL_INVERT] && tbl_hit) |=> accept);

    // R8
    inverted_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && ctrl[CTL_CMP_ON] && ctrl[CTL_INVERT] && !tbl_hit) |=> accept);

    // R9
    no_rule_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !ctrl[CTL_CMP_ON] &&
         !ctrl[CTL_BCAST] && !ctrl[CTL_MCAST] && !ctrl[CTL_UCAST]) |=> !accept);
endmodule

bind rx_screen rx_screen_chk #(.ADDR_W(ADDR_W)) i_rx_screen_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .dst_valid (dst_valid),
    .dst_addr  (dst_addr),
    .tbl_hit   (tbl_hit),
    .done      (done),
    .accept    (accept)
);

// File: tb/test_rx_screen.sv
module test_rx_screen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ctrl = '0;
    logic [15:0] entry_en = '0;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        dst_valid = 1'b0;
    logic [47:0] dst_addr = '0;
    logic        done;
    logic        accept;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [31:0] sh_hi [16];
    logic [15:0] sh_lo [16];

    always #2.5 clk = ~clk;

    rx_screen i_rx_screen (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .entry_en(entry_en),
        .wr_en(wr_en), .wr_hi(wr_hi), .wr_idx(wr_idx), .wr_data(wr_data),
        .dst_valid(dst_valid), .dst_addr(dst_addr),
        .done(done), .accept(accept)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog got=expired exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic model(input logic [47:0] a);
        logic hit = 1'b0;
        logic cls_ok;
        for (int i = 0; i < 16; i++)
            if (entry_en[i] && {sh_hi[i], sh_lo[i]} == a) hit = 1'b1;
        if (&a)        cls_ok = ctrl[2];
        else if (a[40]) cls_ok = ctrl[1];
        else            cls_ok = ctrl[0];
        return cls_ok || (ctrl[4] && (hit ^ ctrl[3]));
    endfunction

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
        end
    endtask

    task automatic write_word(input int idx, input logic hi, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = hi; wr_idx = idx[3:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (hi) sh_hi[idx] = d; else sh_lo[idx] = d[15:0];
    endtask

    task automatic load_entry(input int idx, input logic [47:0] a);
        write_word(idx, 1'b1, a[47:16]);
        write_word(idx, 1'b0, {16'hA5C3, a[15:0]});
    endtask

    task automatic lookup(input logic [47:0] a, input string tag);
        logic e;
        e = model(a);
        @(negedge clk);
        dst_addr = a; dst_valid = 1'b1;
        @(negedge clk);
        dst_valid = 1'b0;
        check({tag, " R2 done"}, done, 1'b1);
        check(tag, accept, e);
        @(negedge clk);
        check("R2 done drop", done, 1'b0);
        check("R11 hold", accept, e);
    endtask

    task automatic expect_lookup(input logic [47:0] a, input logic exp, input string tag);
        check({tag, " model"}, model(a), exp);
        lookup(a, tag);
    endtask

    localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MC  = 48'h0100_5E00_0001;
    localparam logic [47:0] UC  = 48'h0002_B3C4_D5E6;
    localparam logic [47:0] UC2 = 48'h0011_2233_4455;

    initial begin
        logic [47:0] a1, a2;
        logic e1, e2;
        void'($urandom(32'd20251));
        for (int i = 0; i < 16; i++) begin sh_hi[i] = '0; sh_lo[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", done, 1'b0);
        check("R1 accept", accept, 1'b0);
        expect_lookup(BC, 1'b0, "R1 reset bcast");
        expect_lookup(UC, 1'b0, "R1 reset ucast");
        ctrl = 5'b10000; entry_en = 16'h0001;
        expect_lookup(48'h0, 1'b1, "R1 entry zero");

        ctrl = 5'b00100; entry_en = '0;
        expect_lookup(BC, 1'b1, "R3 bcast");
        expect_lookup(MC, 1'b0, "R3 mcast off");
        ctrl = 5'b00010;
        expect_lookup(MC, 1'b1, "R4 mcast");
        expect_lookup(BC, 1'b0, "R4 bcast not mcast");
        ctrl = 5'b00001;
        expect_lookup(UC, 1'b1, "R5 ucast");
        expect_lookup(MC, 1'b0, "R5 mcast off");

        load_entry(5, UC2);
        load_entry(9, MC);
        ctrl = 5'b10000; entry_en = 16'h0220;
        expect_lookup(UC2, 1'b1, "R6 hit e5");
        expect_lookup(MC, 1'b1, "R6 hit e9");
        expect_lookup(UC2 ^ 48'h1, 1'b0, "R6 one bit off");
        expect_lookup(UC, 1'b0, "R10 lo upper bits dropped");
        entry_en = 16'h0200;
        expect_lookup(UC2, 1'b0, "R7 entry off");
        ctrl = 5'b11000;
        expect_lookup(UC2, 1'b1, "R8 inv nohit");
        expect_lookup(MC, 1'b0, "R8 inv hit");
        ctrl = 5'b11010;
        expect_lookup(MC, 1'b1, "R8 inv hit class");
        ctrl = 5'b01000; entry_en = 16'hFFFF;
        expect_lookup(UC, 1'b0, "R9 invert ignored");
        ctrl = 5'b00000;
        expect_lookup(UC2, 1'b0, "R9 table ignored");

        ctrl = 5'b10000; entry_en = 16'h0020;
        write_word(5, 1'b0, 32'hFFFF_7777);
        expect_lookup({UC2[47:16], 16'h7777}, 1'b1, "R10 lo write");
        write_word(5, 1'b1, 32'hDEAD_BEE0);
        expect_lookup({32'hDEAD_BEE0, 16'h7777}, 1'b1, "R10 hi write");

        ctrl = 5'b00100;
        a1 = BC; a2 = UC;
        e1 = model(a1); e2 = model(a2);
        @(negedge clk); dst_addr = a1; dst_valid = 1'b1;
        @(negedge clk); dst_addr = a2;
        check("R2 chain first done", done, 1'b1);
        check("R2 chain first", accept, e1);
        @(negedge clk); dst_valid = 1'b0;
        check("R2 chain second done", done, 1'b1);
        check("R2 chain second", accept, e2);
        @(negedge clk);
        check("R2 chain end", done, 1'b0);

        for (int n = 0; n < 400; n++) begin
            logic [47:0] a;
            int pick;
            if ($urandom_range(0, 7) == 0)
                load_entry($urandom_range(0, 15),
                           {$urandom(), 16'($urandom())} & 48'hFEFF_FFFF_FFFF);
            ctrl = 5'($urandom());
            entry_en = 16'($urandom());
            pick = $urandom_range(0, 4);
            case (pick)
                0: a = BC;
                1: a = {$urandom(), 16'($urandom())} | 48'h0100_0000_0000;
                2: begin
                    int k = $urandom_range(0, 15);
                    a = {sh_hi[k], sh_lo[k]};
                end
                default: a = {$urandom(), 16'($urandom())};
            endcase
            lookup(a, "R6 R8 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule